// File: doc/BRIEF.md
# Chainable Funnel Shifter with Spill Register

This block shifts or rotates a 16-bit word left or right by zero to four places in a single combinational pass. The bits pushed off the end of the word are captured in a small 4-bit spill register on the clock edge, but only when the shift is enabled and the amount is non-zero. The spill register is always visible on its own output port, which serves as the move path that reads it back.

With the chain input set, the vacated positions of the word are filled from the spill register instead of zeros or wrapped bits. A long shift can therefore walk through a multi-word operand one word per cycle. A left shift starts at the least significant word and a right shift starts at the most significant word. The spill bits are always stored right-aligned, so the same register feeds the next word in either direction. Arithmetic shifts are not provided.

The datapath is one staged funnel: log2 layers of 2:1 multiplexers over a 20-bit window. A left shift reuses that funnel with the complementary amount. A few AND/OR gates do the masking and select the fill bits.

Top module: `chain_funnel_shifter`

## Requirements
- R1: After reset the spill register output `spill_o` is 0.
- R2: An effective amount of 0 gives `result_o == data_i`, and `spill_o` stays unchanged even with `shift_en_i` high.
- R3: A logical left shift (`dir_i`=0, `rot_i`=0, `chain_i`=0) by n gives `data_i << n`, with the low n bits zero.
- R4: A logical right shift (`dir_i`=1, `rot_i`=0, `chain_i`=0) by n gives `data_i >> n`, with the top n bits zero.
- R5: With `rot_i`=1 and `chain_i`=0, the word rotates by n in the selected direction, and the bits that leave one end re-enter at the other end.
- R6: With `chain_i`=1, the vacated positions take `spill_o[n-1:0]`. On a left shift this lands in `result_o[n-1:0]`. On a right shift it lands in `result_o[15:16-n]`, with bit order kept. Chain takes priority over `rot_i`.
- R7: A cycle with `shift_en_i`=1 and n>0 loads `spill_o` with the bits shifted out, right-aligned, and zeros above. A left shift loads `data_i[15:16-n]`; a right shift loads `data_i[n-1:0]`. This holds in every mode.
- R8: While `shift_en_i`=0, `spill_o` keeps its value, but `result_o` is still computed.
- R9: Values of `amt_i` above 4 act as 4.
- R10: `result_o` is combinational. It is valid in the cycle the inputs are applied and uses the spill value held before that cycle's capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| shift_en_i | input | 1 | Capture the shifted-out bits on this edge |
| dir_i | input | 1 | 0 = left, 1 = right |
| rot_i | input | 1 | 0 = logical, 1 = rotate |
| chain_i | input | 1 | Fill vacated bits from the spill register |
| amt_i | input | 3 | Shift amount, saturated at 4 |
| data_i | input | 16 | Word to shift |
| result_o | output | 16 | Shifted word |
| spill_o | output | 4 | Spill register contents (move path) |

## Verification
The hardest case to reach is a chained operation whose fill comes from a spill captured under a different amount or direction. The same case arises when a disabled cycle sits between the capture and the use. The bench reaches it through multi-word sequences that it checks against 48-bit reference shifts. It also runs a stream of random operations in which the enable, chain, direction and amount change every cycle. In that stream the spill value carried in the model is whatever the previous enabled operation left behind.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned MAX_SH = 4;
  localparam int unsigned AMT_W  = 3;

  localparam logic DIR_LEFT   = 1'b0;
  localparam logic DIR_RIGHT  = 1'b1;
  localparam logic MODE_LOGIC = 1'b0;
  localparam logic MODE_ROT   = 1'b1;
endpackage

// File: rtl/cfs_amt_sat.sv
module cfs_amt_sat #(
  parameter int unsigned AMT_W  = 3,
  parameter int unsigned MAX_SH = 4,
  parameter int unsigned SH_W   = $clog2(MAX_SH + 1)
) (
  input  logic [AMT_W-1:0] amt_i,
  output logic [SH_W-1:0]  amt_o
);
  logic [AMT_W-1:0] amt_lim;

  always_comb begin
    if (amt_i > AMT_W'(MAX_SH)) begin
      amt_lim = AMT_W'(MAX_SH);
    end else begin
      amt_lim = amt_i;
    end
    amt_o = SH_W'(amt_lim);
  end
endmodule

// File: rtl/cfs_funnel.sv
module cfs_funnel #(
  parameter int unsigned OUT_W = 16,
  parameter int unsigned EXT_W = 4,
  parameter int unsigned SH_W  = 3
) (
  input  logic [OUT_W+EXT_W-1:0] din_i,
  input  logic [SH_W-1:0]        amt_i,
  output logic [OUT_W-1:0]       dout_o
);
  localparam int unsigned TOT_W = OUT_W + EXT_W;

  logic [TOT_W-1:0] stage [SH_W+1];

  assign stage[0] = din_i;

  for (genvar k = 0; k < SH_W; k++) begin : g_layer
    assign stage[k+1] = amt_i[k] ? (stage[k] >> (2**k)) : stage[k];
  end

  assign dout_o = stage[SH_W][OUT_W-1:0];
endmodule

// File: rtl/cfs_fill.sv
module cfs_fill #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned MAX_SH = 4,
  parameter int unsigned SH_W   = 3
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [SH_W-1:0]   amt_i,
  input  logic              dir_i,
  input  logic              rot_i,
  input  logic              chain_i,
  input  logic [MAX_SH-1:0] spill_i,
  output logic [MAX_SH-1:0] fill_o,
  output logic [MAX_SH-1:0] out_bits_o
);
  logic [MAX_SH-1:0] mask;
  logic [MAX_SH-1:0] out_left;
  logic [MAX_SH-1:0] out_right;

  always_comb begin
    mask      = '0;
    out_left  = '0;
    out_right = '0;
    for (int i = 0; i < int'(MAX_SH); i++) begin
      if (i < int'(amt_i)) begin
        mask[i]      = 1'b1;
        out_right[i] = data_i[i];
        out_left[i]  = data_i[int'(DATA_W) - int'(amt_i) + i];
      end
    end
  end

  always_comb begin
    out_bits_o = (dir_i == cfs_pkg::DIR_RIGHT) ? out_right : out_left;
    if (chain_i) begin
      fill_o = spill_i & mask;
    end else if (rot_i == cfs_pkg::MODE_ROT) begin
      fill_o = out_bits_o;
    end else begin
      fill_o = '0;
    end
  end
endmodule

// File: rtl/cfs_spill_reg.sv
module cfs_spill_reg #(
  parameter int unsigned MAX_SH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MAX_SH-1:0] bits_i,
  output logic [MAX_SH-1:0] spill_o
);
  logic [MAX_SH-1:0] spill_d;
  logic [MAX_SH-1:0] spill_q;

  always_comb begin
    if (load_i) begin
      spill_d = bits_i;
    end else begin
      spill_d = spill_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spill_q <= '0;
    end else begin
      spill_q <= spill_d;
    end
  end

  assign spill_o = spill_q;

  // R8: no load request means the held spill bits survive the edge
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(spill_q));
endmodule

// File: rtl/chain_funnel_shifter.sv
module chain_funnel_shifter #(
  parameter int unsigned DATA_W = cfs_pkg::DATA_W,
  parameter int unsigned MAX_SH = cfs_pkg::MAX_SH,
  parameter int unsigned AMT_W  = cfs_pkg::AMT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              dir_i,
  input  logic              rot_i,
  input  logic              chain_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] result_o,
  output logic [MAX_SH-1:0] spill_o
);
  localparam int unsigned SH_W  = $clog2(MAX_SH + 1);
  localparam int unsigned WIN_W = DATA_W + MAX_SH;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  logic [SH_W-1:0]   amt_sat;
  logic [SH_W-1:0]   amt_win;
  logic [MAX_SH-1:0] fill;
  logic [MAX_SH-1:0] fill_lo;
  logic [MAX_SH-1:0] out_bits;
  logic [WIN_W-1:0]  window;
  logic              spill_load;

  cfs_amt_sat #(
    .AMT_W (AMT_W),
    .MAX_SH(MAX_SH),
    .SH_W  (SH_W)
  ) u_sat (
    .amt_i(amt_i),
    .amt_o(amt_sat)
  );

  cfs_fill #(
    .DATA_W(DATA_W),
    .MAX_SH(MAX_SH),
    .SH_W  (SH_W)
  ) u_fill (
    .data_i    (data_i),
    .amt_i     (amt_sat),
    .dir_i     (dir_i),
    .rot_i     (rot_i),
    .chain_i   (chain_i),
    .spill_i   (spill_o),
    .fill_o    (fill),
    .out_bits_o(out_bits)
  );

  // move the right-aligned fill to the top of the low extension for left shifts
  cfs_funnel #(
    .OUT_W(MAX_SH),
    .EXT_W(MAX_SH),
    .SH_W (SH_W)
  ) u_fill_align (
    .din_i ({fill, {MAX_SH{1'b0}}}),
    .amt_i (amt_sat),
    .dout_o(fill_lo)
  );

  // a left shift by n is a right funnel of {data, fill_lo} by MAX_SH-n
  always_comb begin
    if (dir_i == cfs_pkg::DIR_RIGHT) begin
      window  = {fill, data_i};
      amt_win = amt_sat;
    end else begin
      window  = {data_i, fill_lo};
      amt_win = SH_W'(MAX_SH) - amt_sat;
    end
  end

  cfs_funnel #(
    .OUT_W(DATA_W),
    .EXT_W(MAX_SH),
    .SH_W (SH_W)
  ) u_main (
    .din_i (window),
    .amt_i (amt_win),
    .dout_o(result_o)
  );

  assign spill_load = shift_en_i && (amt_sat != '0);

  cfs_spill_reg #(
    .MAX_SH(MAX_SH)
  ) u_spill (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .load_i (spill_load),
    .bits_i (out_bits),
    .spill_o(spill_o)
  );

  // R2: zero amount passes the word through
  a_r2_zero_pass: assert property (@(posedge clk_i) disable iff (!rst_n)
    (amt_i == '0) |-> (result_o == data_i));

  // R3: single-place logical left shift
  a_r3_left_one: assert property (@(posedge clk_i) disable iff (!rst_n)
    (amt_i == AMT_W'(1) && dir_i == cfs_pkg::DIR_LEFT && !rot_i && !chain_i)
      |-> (result_o == (data_i << 1)));

  // R5: a single-word rotate keeps the population count
  a_r5_rot_pop: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rot_i && !chain_i) |-> ($countones(result_o) == $countones(data_i)));

  // R6: chained left shift takes its lowest bit from the spill register
  a_r6_chain_left: assert property (@(posedge clk_i) disable iff (!rst_n)
    (chain_i && dir_i == cfs_pkg::DIR_LEFT && amt_i != '0)
      |-> (result_o[0] == spill_o[0]));

  // R7: right shift spills the old LSB into spill bit 0
  a_r7_right_capture: assert property (@(posedge clk_i) disable iff (!rst_n)
    (shift_en_i && dir_i == cfs_pkg::DIR_RIGHT && amt_i != '0)
      |=> (spill_o[0] == $past(data_i[0])));

  // R7: spill bits above the captured count are zero
  a_r7_upper_clear: assert property (@(posedge clk_i) disable iff (!rst_n)
    (shift_en_i && amt_i != '0) |=> ((spill_o >> $past(amt_sat)) == '0));

  // R9: an oversize amount acts as the maximum on a logical left shift
  a_r9_saturate: assert property (@(posedge clk_i) disable iff (!rst_n)
    (amt_i > AMT_W'(MAX_SH) && dir_i == cfs_pkg::DIR_LEFT && !rot_i && !chain_i)
      |-> (result_o == (data_i << MAX_SH)));
endmodule

// File: tb/chain_funnel_shifter_tb.sv
module chain_funnel_shifter_tb;
  localparam time HALF = 10ns;

  logic        clk;
  logic        rst_n;
  logic        shift_en;
  logic        dir;
  logic        rot;
  logic        chain;
  logic [2:0]  amt;
  logic [15:0] data;
  logic [15:0] result;
  logic [3:0]  spill;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [15:0] res;
    logic [3:0]  side;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  logic [3:0]  model_side = 4'h0;
  logic        done = 1'b0;

  chain_funnel_shifter u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .shift_en_i(shift_en),
    .dir_i     (dir),
    .rot_i     (rot),
    .chain_i   (chain),
    .amt_i     (amt),
    .data_i    (data),
    .result_o  (result),
    .spill_o   (spill)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // reference built from the requirement text
  function automatic item_t model(input logic [15:0] d, input logic [2:0] a,
                                  input logic dr, input logic rt, input logic ch,
                                  input logic en, input logic [3:0] side,
                                  input string tag);
    item_t it;
    int n;
    logic [15:0] outb;
    logic [15:0] fillb;
    logic [15:0] msk;
    n = (a > 3'd4) ? 4 : int'(a);
    it.tag = tag;
    if (n == 0) begin
      it.res  = d;
      it.side = side;
    end else begin
      msk  = (16'h1 << n) - 16'h1;
      outb = dr ? (d & msk) : (d >> (16 - n));
      if (ch)      fillb = {12'h0, side} & msk;
      else if (rt) fillb = outb;
      else         fillb = 16'h0;
      if (dr) it.res = (d >> n) | (fillb << (16 - n));
      else    it.res = (d << n) | fillb;
      it.side = en ? outb[3:0] : side;
    end
    return it;
  endfunction

  task automatic drive(input logic en, input logic dr, input logic rt,
                       input logic ch, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    shift_en = en; dir = dr; rot = rt; chain = ch; amt = a; data = d;
  endtask

  task automatic apply(input string tag, input logic en, input logic dr,
                       input logic rt, input logic ch, input logic [2:0] a,
                       input logic [15:0] d);
    item_t it;
    drive(en, dr, rt, ch, a, d);
    it = model(d, a, dr, rt, ch, en, model_side, tag);
    model_side = it.side;
    sb_q.push_back(it);
  endtask

  task automatic apply_exp(input string tag, input logic dr, input logic ch,
                           input logic [2:0] a, input logic [15:0] d,
                           input logic [15:0] exp_res, input logic [3:0] exp_side);
    item_t it;
    drive(1'b1, dr, 1'b0, ch, a, d);
    it.res = exp_res; it.side = exp_side; it.tag = tag;
    model_side = exp_side;
    sb_q.push_back(it);
  endtask

  // monitor: result mid-low phase, spill after the next rising edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #5ns;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check(it.tag, "result", result, it.res);
        @(posedge clk);
        #5ns;
        check(it.tag, "spill", {12'h0, spill}, {12'h0, it.side});
      end
    end
  end

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] wide;
    logic [47:0] shl;
    logic [47:0] shr;
    shift_en = 1'b0; dir = 1'b0; rot = 1'b0; chain = 1'b0; amt = 3'd0; data = 16'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #5ns;
    check("R1", "spill after reset", {12'h0, spill}, 16'h0);

    // R2: zero amount, enabled
    apply("R2", 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 16'hA5C3);
    apply("R2", 1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 16'h5A3C);
    // R3: logical left
    apply("R3", 1'b1, 1'b0, 1'b0, 1'b0, 3'd3, 16'hF00F);
    apply("R3", 1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 16'h8001);
    // R4: logical right
    apply("R4", 1'b1, 1'b1, 1'b0, 1'b0, 3'd2, 16'h8003);
    apply("R4", 1'b1, 1'b1, 1'b0, 1'b0, 3'd4, 16'hFFFF);
    // R5: rotates
    apply("R5", 1'b1, 1'b0, 1'b1, 1'b0, 3'd4, 16'h1234);
    apply("R5", 1'b1, 1'b1, 1'b1, 1'b0, 3'd1, 16'h0001);
    // R6 / R10: chain, fill from spill held before the edge
    apply("R7", 1'b1, 1'b0, 1'b0, 1'b0, 3'd2, 16'hC000);
    apply("R6", 1'b1, 1'b0, 1'b1, 1'b1, 3'd2, 16'h0000);
    apply("R10", 1'b1, 1'b1, 1'b0, 1'b1, 3'd3, 16'h0007);
    // R8: disabled cycles keep spill
    apply("R7", 1'b1, 1'b1, 1'b0, 1'b0, 3'd3, 16'h0005);
    apply("R8", 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 16'hF000);
    apply("R8", 1'b0, 1'b1, 1'b1, 1'b0, 3'd2, 16'h0003);
    apply("R6", 1'b1, 1'b1, 1'b0, 1'b1, 3'd3, 16'h0000);
    // R9: saturation
    apply("R9", 1'b1, 1'b0, 1'b0, 1'b0, 3'd7, 16'hBEEF);
    apply("R9", 1'b1, 1'b1, 1'b1, 1'b0, 3'd5, 16'hBEEF);

    // R6 multi-word left shift by 3, least significant word first
    wide = 48'h9ABC_DEF0_1357;
    shl  = wide << 3;
    apply_exp("R6", 1'b0, 1'b0, 3'd3, wide[15:0],  shl[15:0],  {1'b0, wide[15:13]});
    apply_exp("R6", 1'b0, 1'b1, 3'd3, wide[31:16], shl[31:16], {1'b0, wide[31:29]});
    apply_exp("R6", 1'b0, 1'b1, 3'd3, wide[47:32], shl[47:32], {1'b0, wide[47:45]});
    // R6 multi-word right shift by 2, most significant word first
    wide = 48'hF00D_8421_C3A5;
    shr  = wide >> 2;
    apply_exp("R6", 1'b1, 1'b0, 3'd2, wide[47:32], shr[47:32], {2'b0, wide[33:32]});
    apply_exp("R6", 1'b1, 1'b1, 3'd2, wide[31:16], shr[31:16], {2'b0, wide[17:16]});
    apply_exp("R6", 1'b1, 1'b1, 3'd2, wide[15:0],  shr[15:0],  {2'b0, wide[1:0]});

    // mixed stream (R7 capture in every mode)
    for (int k = 0; k < 60; k++) begin
      logic [15:0] rd;
      logic [7:0]  ctl;
      rd  = 16'($urandom);
      ctl = 8'($urandom);
      apply("R7", ctl[0] | ctl[7], ctl[1], ctl[2], ctl[3], ctl[6:4], rd);
    end

    drive(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 16'h0);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule